// File: doc/BRIEF.md
# Framebuffer Write Pixel Packer

This block takes a stream of 32-bit RGBA pixels (8 bits per channel) and turns each one into a 16-bit framebuffer word. A 2-bit format select picks one of four layouts. Two of them carry a one-bit flag in bit 15: one copies the top bit of an 8-bit key value, the other compares alpha against an 8-bit threshold. Every channel is narrowed by dropping its low bits. No rounding is applied.

Lines are counted against a programmed width in pixels. After the last word of each line, the block reports how many 16-bit slots the writer must step over to reach the next line. The line pitch is given in 8-byte units, so one pitch unit covers four 16-bit words. The format, key, threshold, width and pitch are taken from their inputs on the pixel flagged as start of frame, and they are held for the rest of that frame. A downstream address generator uses the word stream and the skip reports to place data in memory. Address generation is not part of this block.

Top module: `fbpk_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` and `pad_vld` are 0 and `in_ready` is 1.
- R2: Format code 2'b00 produces {key[7], R[7:3], G[7:3], B[7:3]}, with red in bits 14:10, green in 9:5, blue in 4:0 and bit 15 equal to bit 7 of the key.
- R3: Format code 2'b01 produces {R[7:3], G[7:2], B[7:3]}, with red in bits 15:11, green in 10:5 and blue in 4:0.
- R4: Format code 2'b10 produces {A[7:4], R[7:4], G[7:4], B[7:4]}, with the alpha nibble in bits 15:12.
- R5: Format code 2'b11 places the colour channels as in R2 and sets bit 15 only when A is strictly greater than the threshold. When A equals the threshold, bit 15 is 0.
- R6: Channels are narrowed by truncation. Low bits that are discarded never carry into the kept bits, so a channel value of 8'h07 gives a 5-bit field of 0.
- R7: Format, key, threshold, width and pitch are captured when a pixel with `in_sof` = 1 is accepted, and that pixel already uses the new values. Changes on these inputs before the next such pixel have no effect on the output words, line ends or skip counts.
- R8: `out_last` is 1 on the word of every width-th pixel counted from the start of frame. One cycle after that word is transferred, `pad_vld` pulses with `pad_cnt` = pitch*4 − width.
- R9: When pitch*4 is less than or equal to width, the skip count reported is 0.
- R10: `in_ready` = !`out_valid` || `out_ready`. While `out_valid` is 1 and `out_ready` is 0, the output word and its last flag stay unchanged on the next cycle.
- R11: A pixel accepted at a clock edge appears on `out_data` with `out_valid` = 1 right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel present |
| in_ready | output | 1 | Pixel can be taken |
| in_sof | input | 1 | Pixel is the first of a frame; capture controls |
| in_r | input | 8 | Red channel |
| in_g | input | 8 | Green channel |
| in_b | input | 8 | Blue channel |
| in_a | input | 8 | Alpha channel |
| ctl_mode | input | 2 | Output format code |
| ctl_key | input | 8 | Key value; bit 7 feeds format 2'b00 |
| ctl_thresh | input | 8 | Alpha threshold for format 2'b11 |
| ctl_width | input | WIDTH_W | Pixels per line |
| ctl_pitch | input | PITCH_W | Line pitch in 8-byte units |
| out_valid | output | 1 | Word present |
| out_ready | input | 1 | Word taken downstream |
| out_data | output | 16 | Packed word |
| out_last | output | 1 | Word ends a line |
| pad_vld | output | 1 | Skip count valid pulse |
| pad_cnt | output | PITCH_W+2 | Number of 16-bit slots to skip after the line |

## Verification
The bench builds the packer with a 6-bit width field and a 4-bit pitch field. Lines are therefore only a few pixels long, and both positive skip counts and the clamp to zero are easy to reach within short frames. With such short lines, line ends occur often enough that many of them meet a stalled output. This tests whether the word, the last flag and the following skip pulse stay aligned. Between frame starts, the controls are deliberately driven to other values, which shows that the held copy governs the output.

// File: rtl/fbpk_pkg.sv
package fbpk_pkg;

    typedef enum logic [1:0] {
        FMT_K555  = 2'b00,
        FMT_565   = 2'b01,
        FMT_4444  = 2'b10,
        FMT_A1555 = 2'b11
    } fmt_e;

    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
        logic [7:0] a;
    } rgba_t;

    typedef struct packed {
        fmt_e       fmt;
        logic [7:0] key;
        logic [7:0] thresh;
    } look_t;

    typedef struct packed {
        logic [15:0] data;
        logic        last;
    } word_t;

    function automatic logic [15:0] pack_px(rgba_t p, look_t c);
        logic [15:0] w;
        unique case (c.fmt)
            FMT_K555:  w = {c.key[7], p.r[7:3], p.g[7:3], p.b[7:3]};
            FMT_565:   w = {p.r[7:3], p.g[7:2], p.b[7:3]};
            FMT_4444:  w = {p.a[7:4], p.r[7:4], p.g[7:4], p.b[7:4]};
            default:   w = {(p.a > c.thresh), p.r[7:3], p.g[7:3], p.b[7:3]};
        endcase
        return w;
    endfunction

endpackage

// File: rtl/fbpk_cfg_hold.sv
module fbpk_cfg_hold
    import fbpk_pkg::*;
#(
    parameter int WIDTH_W = 12,
    parameter int PITCH_W = 9
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sel_live,
    input  logic               capture,
    input  look_t              live_look,
    input  logic [WIDTH_W-1:0] live_width,
    input  logic [PITCH_W-1:0] live_pitch,
    output look_t              eff_look,
    output logic [WIDTH_W-1:0] eff_width,
    output logic [PITCH_W-1:0] eff_pitch,
    output look_t              held_look
);

    logic [WIDTH_W-1:0] held_width;
    logic [PITCH_W-1:0] held_pitch;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_look  <= '{fmt: FMT_K555, key: '0, thresh: '0};
            held_width <= '0;
            held_pitch <= '0;
        end else if (capture) begin
            held_look  <= live_look;
            held_width <= live_width;
            held_pitch <= live_pitch;
        end
    end

    always_comb begin
        eff_look  = sel_live ? live_look  : held_look;
        eff_width = sel_live ? live_width : held_width;
        eff_pitch = sel_live ? live_pitch : held_pitch;
    end

endmodule

// File: rtl/fbpk_line_track.sv
module fbpk_line_track #(
    parameter int WIDTH_W = 12,
    parameter int PITCH_W = 9,
    localparam int PAD_W  = PITCH_W + 2,
    localparam int CMP_W  = ((WIDTH_W > PAD_W) ? WIDTH_W : PAD_W) + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               accept,
    input  logic               restart,
    input  logic [WIDTH_W-1:0] width,
    input  logic [PITCH_W-1:0] pitch,
    output logic               is_last,
    output logic [PAD_W-1:0]   skip
);

    logic [WIDTH_W-1:0] col_q;
    logic [WIDTH_W-1:0] col_now;
    logic [CMP_W-1:0]   span_x;
    logic [CMP_W-1:0]   wid_x;

    assign col_now = restart ? '0 : col_q;
    assign is_last = (col_now == width - WIDTH_W'(1));

    assign span_x = CMP_W'({pitch, 2'b00});
    assign wid_x  = CMP_W'(width);
    assign skip   = (span_x > wid_x) ? PAD_W'(span_x - wid_x) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q <= '0;
        end else if (accept) begin
            col_q <= is_last ? '0 : col_now + WIDTH_W'(1);
        end
    end

    // R8: column index stays inside the line
    p_col_bound_r8: assert property (@(posedge clk) disable iff (rst)
        (!restart && width != '0) |-> (col_q < width));

endmodule

// File: rtl/fbpk_out_stage.sv
module fbpk_out_stage
    import fbpk_pkg::*;
#(
    parameter int PAD_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  word_t            load_word,
    input  logic [PAD_W-1:0] load_skip,
    output logic             can_load,
    output logic             out_valid,
    input  logic             out_ready,
    output word_t            out_word,
    output logic             pad_vld,
    output logic [PAD_W-1:0] pad_cnt
);

    logic [PAD_W-1:0] skip_q;
    logic             xfer;

    assign can_load = !out_valid || out_ready;
    assign xfer     = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_word  <= '0;
            skip_q    <= '0;
            pad_vld   <= 1'b0;
            pad_cnt   <= '0;
        end else begin
            if (load) begin
                out_valid <= 1'b1;
                out_word  <= load_word;
                skip_q    <= load_skip;
            end else if (xfer) begin
                out_valid <= 1'b0;
            end
            pad_vld <= xfer && out_word.last;
            if (xfer && out_word.last) begin
                pad_cnt <= skip_q;
            end
        end
    end

    // R10: a stalled word holds
    p_stall_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

    // R8: skip pulse only follows a transferred line end
    p_pad_follow_r8: assert property (@(posedge clk) disable iff (rst)
        pad_vld |-> $past(out_valid && out_ready && out_word.last));

endmodule

// File: rtl/fbpk_top.sv
module fbpk_top
    import fbpk_pkg::*;
#(
    parameter int WIDTH_W = 12,
    parameter int PITCH_W = 9,
    localparam int PAD_W  = PITCH_W + 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic               in_sof,
    input  logic [7:0]         in_r,
    input  logic [7:0]         in_g,
    input  logic [7:0]         in_b,
    input  logic [7:0]         in_a,
    input  logic [1:0]         ctl_mode,
    input  logic [7:0]         ctl_key,
    input  logic [7:0]         ctl_thresh,
    input  logic [WIDTH_W-1:0] ctl_width,
    input  logic [PITCH_W-1:0] ctl_pitch,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [15:0]        out_data,
    output logic               out_last,
    output logic               pad_vld,
    output logic [PAD_W-1:0]   pad_cnt
);

    look_t              live_look;
    look_t              eff_look;
    look_t              held_look;
    logic [WIDTH_W-1:0] eff_width;
    logic [PITCH_W-1:0] eff_pitch;
    logic               accept;
    logic               is_last;
    logic [PAD_W-1:0]   skip;
    rgba_t              px;
    word_t              new_word;
    word_t              cur_word;

    assign live_look = '{fmt: fmt_e'(ctl_mode), key: ctl_key, thresh: ctl_thresh};
    assign accept    = in_valid && in_ready;
    assign px        = '{r: in_r, g: in_g, b: in_b, a: in_a};
    assign new_word  = '{data: pack_px(px, eff_look), last: is_last};

    fbpk_cfg_hold #(.WIDTH_W(WIDTH_W), .PITCH_W(PITCH_W)) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .sel_live   (in_sof),
        .capture    (accept && in_sof),
        .live_look  (live_look),
        .live_width (ctl_width),
        .live_pitch (ctl_pitch),
        .eff_look   (eff_look),
        .eff_width  (eff_width),
        .eff_pitch  (eff_pitch),
        .held_look  (held_look)
    );

    fbpk_line_track #(.WIDTH_W(WIDTH_W), .PITCH_W(PITCH_W)) u_line (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .restart (in_sof),
        .width   (eff_width),
        .pitch   (eff_pitch),
        .is_last (is_last),
        .skip    (skip)
    );

    fbpk_out_stage #(.PAD_W(PAD_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .load_word (new_word),
        .load_skip (skip),
        .can_load  (in_ready),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_word  (cur_word),
        .pad_vld   (pad_vld),
        .pad_cnt   (pad_cnt)
    );

    assign out_data = cur_word.data;
    assign out_last = cur_word.last;

    // R2: key flag in the held frame settings reaches bit 15
    p_key_bit_r2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && held_look.fmt == FMT_K555) |-> (out_data[15] == held_look.key[7]));

    // R10: an empty output stage always takes a pixel
    p_ready_empty_r10: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready);

endmodule

// File: tb/fbpk_top_bench.sv
module fbpk_top_bench;

    localparam int WIDTH_W = 6;
    localparam int PITCH_W = 4;
    localparam int PAD_W   = PITCH_W + 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic               in_ready;
    logic               in_sof = 1'b0;
    logic [7:0]         in_r = '0, in_g = '0, in_b = '0, in_a = '0;
    logic [1:0]         ctl_mode = '0;
    logic [7:0]         ctl_key = '0, ctl_thresh = '0;
    logic [WIDTH_W-1:0] ctl_width = '0;
    logic [PITCH_W-1:0] ctl_pitch = '0;
    logic               out_valid;
    logic               out_ready = 1'b1;
    logic [15:0]        out_data;
    logic               out_last;
    logic               pad_vld;
    logic [PAD_W-1:0]   pad_cnt;

    fbpk_top #(.WIDTH_W(WIDTH_W), .PITCH_W(PITCH_W)) u_fbpk_top (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_sof(in_sof), .in_r(in_r), .in_g(in_g), .in_b(in_b), .in_a(in_a),
        .ctl_mode(ctl_mode), .ctl_key(ctl_key), .ctl_thresh(ctl_thresh),
        .ctl_width(ctl_width), .ctl_pitch(ctl_pitch), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
        .pad_vld(pad_vld), .pad_cnt(pad_cnt)
    );

    typedef struct {
        logic [15:0] d;
        logic        l;
        string       tag;
    } exp_word_t;

    typedef struct {
        int    n;
        string tag;
    } exp_pad_t;

    exp_word_t wq[$];
    exp_pad_t  pq[$];
    int n_chk = 0;
    int n_bad = 0;
    bit rnd_ready = 1'b0;

    // bench copy of frame settings
    logic [1:0] f_mode;
    logic [7:0] f_key, f_thr;
    int         f_w, f_p, bcol;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] model(input logic [1:0] m, input logic [7:0] k,
                                          input logic [7:0] t, input logic [7:0] r,
                                          input logic [7:0] g, input logic [7:0] b,
                                          input logic [7:0] a);
        case (m)
            2'd0: return {k[7], r[7:3], g[7:3], b[7:3]};
            2'd1: return {r[7:3], g[7:2], b[7:3]};
            2'd2: return {a[7:4], r[7:4], g[7:4], b[7:4]};
            default: return {(a > t), r[7:3], g[7:3], b[7:3]};
        endcase
    endfunction

    // downstream ready pattern, changes just after the rising edge
    always @(posedge clk) begin
        #1;
        out_ready = rnd_ready ? (($urandom % 4) != 0) : 1'b1;
    end

    // monitor: compares words and skip pulses
    bit        stall_prev = 1'b0;
    logic [15:0] stall_d;
    logic        stall_l;
    always @(negedge clk) begin
        if (!rst) begin
            if (stall_prev) begin
                // R10: stalled word held
                check(out_valid && out_data == stall_d && out_last == stall_l,
                      "R10", {out_valid, out_data}, {1'b1, stall_d});
            end
            stall_prev = out_valid && !out_ready;
            stall_d = out_data;
            stall_l = out_last;
            if (out_valid && out_ready) begin
                if (wq.size() == 0) begin
                    check(1'b0, "R11 extra word", out_data, 0);
                end else begin
                    exp_word_t e;
                    e = wq.pop_front();
                    check(out_data == e.d, e.tag, out_data, e.d);
                    check(out_last == e.l, "R8 last", out_last, e.l);
                end
            end
            if (pad_vld) begin
                if (pq.size() == 0) begin
                    check(1'b0, "R8 extra pad", pad_cnt, 0);
                end else begin
                    exp_pad_t e;
                    e = pq.pop_front();
                    check(int'(pad_cnt) == e.n, e.tag, pad_cnt, e.n);
                end
            end
        end
    end

    task automatic push_px(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b,
                           input logic [7:0] a, input bit sof, input string tag);
        exp_word_t e;
        exp_pad_t  p;
        bit        last;
        @(negedge clk);
        in_valid = 1'b1;
        in_sof = sof;
        in_r = r; in_g = g; in_b = b; in_a = a;
        if (sof) begin
            f_mode = ctl_mode; f_key = ctl_key; f_thr = ctl_thresh;
            f_w = int'(ctl_width); f_p = int'(ctl_pitch); bcol = 0;
        end
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        last = (bcol == f_w - 1);
        e.d = model(f_mode, f_key, f_thr, r, g, b, a);
        e.l = last;
        e.tag = tag;
        wq.push_back(e);
        if (last) begin
            p.n = (f_p * 4 > f_w) ? f_p * 4 - f_w : 0;
            p.tag = (p.n == 0) ? "R9" : "R8";
            pq.push_back(p);
            bcol = 0;
        end else begin
            bcol++;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_sof = 1'b0;
    endtask

    // pat 0 random, 1 low-bit corners (R6), 2 alpha around threshold (R5)
    task automatic frame(input logic [1:0] m, input logic [7:0] k, input logic [7:0] t,
                         input int w, input int p, input int lines, input int pat,
                         input string tag);
        @(negedge clk);
        ctl_mode = m; ctl_key = k; ctl_thresh = t;
        ctl_width = WIDTH_W'(w); ctl_pitch = PITCH_W'(p);
        for (int ln = 0; ln < lines; ln++) begin
            for (int c = 0; c < w; c++) begin
                logic [7:0] r, g, b, a;
                r = 8'($urandom); g = 8'($urandom); b = 8'($urandom); a = 8'($urandom);
                if (pat == 1) begin
                    r = 8'h07; g = (c % 2 == 0) ? 8'h03 : 8'hFB; b = 8'h0F; a = 8'h0F;
                end else if (pat == 2) begin
                    a = (c % 3 == 0) ? t : ((c % 3 == 1) ? t + 8'd1 : t - 8'd1);
                end
                push_px(r, g, b, a, (ln == 0 && c == 0), tag);
                if (ln == 0 && c == 0) begin
                    // R7: disturb live controls mid-frame
                    ctl_mode = ~m; ctl_key = ~k; ctl_thresh = ~t;
                    ctl_width = ~WIDTH_W'(w); ctl_pitch = ~PITCH_W'(p);
                end
            end
        end
    endtask

    bit wd_hit = 1'b0;
    initial begin
        #1_900_000;
        wd_hit = 1'b1;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #2;
        // R1: reset state
        check(!out_valid && !pad_vld && in_ready, "R1", {out_valid, pad_vld, in_ready}, 3'b001);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #2;
        check(!out_valid && !pad_vld && in_ready, "R1", {out_valid, pad_vld, in_ready}, 3'b001);

        // R11: one-cycle latency with ready held high
        @(negedge clk);
        ctl_mode = 2'd1; ctl_key = 8'h00; ctl_thresh = 8'h00;
        ctl_width = WIDTH_W'(1); ctl_pitch = PITCH_W'(1);
        push_px(8'hFF, 8'h00, 8'hFF, 8'h00, 1'b1, "R11");
        check(out_valid && out_data == 16'hF81F, "R11", {out_valid, out_data}, {1'b1, 16'hF81F});
        repeat (3) @(posedge clk);

        rnd_ready = 1'b1;
        frame(2'd0, 8'h80, 8'h00, 5, 2, 3, 0, "R2");   // key bit 1, skip 3
        frame(2'd0, 8'h7F, 8'h00, 4, 1, 2, 0, "R2");   // key bit 0, R9 skip 0 at equality
        frame(2'd1, 8'h00, 8'h00, 6, 3, 3, 0, "R3");   // skip 6
        frame(2'd2, 8'h00, 8'h00, 3, 1, 3, 0, "R4");   // skip 1
        frame(2'd3, 8'h00, 8'h80, 7, 4, 2, 2, "R5");   // skip 9
        frame(2'd3, 8'h00, 8'h00, 4, 2, 2, 2, "R5");   // threshold zero edge
        frame(2'd1, 8'h00, 8'h00, 4, 2, 2, 1, "R6");   // truncation corners
        frame(2'd0, 8'h80, 8'h00, 4, 2, 1, 1, "R6");
        frame(2'd2, 8'h00, 8'h00, 20, 2, 2, 0, "R9");  // pitch*4 below width
        frame(2'd3, 8'h00, 8'h40, 1, 15, 5, 2, "R8");  // one-pixel lines, skip 59
        frame(2'd1, 8'h00, 8'h00, 63, 15, 2, 0, "R7"); // long lines, skip 0

        rnd_ready = 1'b0;
        for (int i = 0; i < 200 && (wq.size() != 0 || pq.size() != 0); i++) begin
            @(posedge clk);
        end
        repeat (4) @(posedge clk);
        check(wq.size() == 0, "R8 words drained", wq.size(), 0);
        check(pq.size() == 0, "R8 pads drained", pq.size(), 0);
        if (!wd_hit) begin
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule